// File: doc/BRIEF.md
# Task-Priority Interrupt Filter

This block keeps a single numeric priority threshold and uses it to gate a set of pending external interrupt requests. Each request belongs to one priority class. Class 1 is the least urgent and class 15 the most urgent. A request passes the gate only if its class is strictly greater than the threshold. From the requests that pass, the block picks the most urgent class and presents it with a valid flag.

Software sets the threshold through a plain write/read register port that is 64 bits wide. Only the low nibble carries meaning, and the upper bits always read back as zero. Interrupt sources drive a bitmap indexed by class number. The output is registered, so the winning class appears one clock after the inputs that produced it. Raising the threshold holds back every class up to and including the new value. A threshold of 0 opens the gate completely, and a threshold of 15 closes it.

Top module: `prio_gate`

## Requirements
- R1: After reset the threshold is 0, `win_valid` is 0, `win_class` is 0 and `cfg_err` is 0.
- R2: `cfg_rd_data` returns the threshold in bits [3:0]. Bits [63:4] always read as zero.
- R3: A write (`cfg_wr_en` high at a clock edge) loads `cfg_wr_data[3:0]` into the threshold. Bits [63:4] of the write data never change the stored value.
- R4: A write whose bits [63:4] are not all zero raises `cfg_err` for exactly the one cycle after that edge. All other cycles keep `cfg_err` low.
- R5: A pending class whose number is less than or equal to the threshold is blocked. A pending class whose number is greater than the threshold is eligible.
- R6: With a threshold of 0, every class from 1 to 15 is eligible.
- R7: With a threshold of 15, no class is eligible and `win_valid` stays 0 whatever is pending.
- R8: Bit 0 of `req_pend` stands for a class that does not exist and never affects the output.
- R9: At each clock edge the block registers the highest eligible pending class on `win_class` and sets `win_valid` to 1. If nothing is eligible, it sets `win_valid` to 0 and `win_class` to 0. The output therefore follows its inputs by one cycle.
- R10: A threshold written at edge k first takes part in filtering at edge k+1. The output registered at edge k still uses the old threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Threshold write strobe |
| cfg_wr_data | input | 64 | Write data; bits [3:0] hold the threshold, the rest must be zero |
| cfg_rd_data | output | 64 | Threshold read-back, zero-extended |
| cfg_err | output | 1 | One-cycle strobe: the last write had nonzero reserved bits |
| req_pend | input | 16 | Pending requests; bit n set means class n is pending |
| win_valid | output | 1 | An eligible request exists |
| win_class | output | 4 | Highest eligible pending class, 0 when none |

## Verification
A corrupted threshold shows on `cfg_rd_data` as soon as the clock edge that wrote it has passed. It also shows one edge later as a class wrongly passed or wrongly blocked at the output. An error in the eligibility mask or the priority pick shows on `win_valid`/`win_class` at the edge after the pending pattern is applied. Sweeping patterns that sit just above and just below the threshold exposes off-by-one comparisons within a single cycle. A reserved-bit fault shows either as a changed read-back or as a missing or stretched `cfg_err` pulse on the cycle after the write.

// File: rtl/prio_gate_pkg.sv
package prio_gate_pkg;
  parameter int unsigned CLASS_W = 4;
  localparam int unsigned CLASS_N = 1 << CLASS_W;

  typedef logic [CLASS_W-1:0] class_t;
  typedef logic [CLASS_N-1:0] class_map_t;

  // Class c is let through only when strictly above the threshold.
  function automatic logic passes(input int unsigned c, input class_t thr);
    return (c != 0) && (c > int'(thr));
  endfunction

  // Highest set bit of an eligibility map; bit 0 is never a class.
  function automatic class_t top_class(input class_map_t m);
    class_t r = '0;
    for (int i = CLASS_N - 1; i > 0; i--) begin
      if (m[i] && r == '0) r = class_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/prio_gate_thr_reg.sv
module prio_gate_thr_reg
  import prio_gate_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output class_t           thr,
  output logic             err
);
  localparam int unsigned RSV_W = REG_W - CLASS_W;

  logic rsv_hit;
  assign rsv_hit = wr_en && (wr_data[REG_W-1:CLASS_W] != {RSV_W{1'b0}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= '0;
      err <= 1'b0;
    end else begin
      if (wr_en) thr <= wr_data[CLASS_W-1:0];
      err <= rsv_hit;
    end
  end

  // R3: the stored threshold changes only through a write
  p_thr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(thr));
  // R4: strobe follows a reserved-bit write by exactly one cycle
  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[REG_W-1:CLASS_W] != '0)) |=> err);
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_data[REG_W-1:CLASS_W] != '0)) |=> !err);
endmodule

// File: rtl/prio_gate_pick.sv
module prio_gate_pick
  import prio_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  class_map_t req,
  input  class_t     thr,
  output logic       valid,
  output class_t     cls
);
  class_map_t elig;
  logic       unused_cls0;

  assign unused_cls0 = req[0];
  assign elig[0]     = 1'b0;

  genvar c;
  generate
    for (c = 1; c < CLASS_N; c++) begin : g_gate
      assign elig[c] = req[c] && passes(c, thr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cls   <= '0;
    end else begin
      valid <= |elig;
      cls   <= top_class(elig);
    end
  end

  // R5: a reported class is above the threshold it was filtered with
  p_win_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cls > $past(thr)));
  // R9: the reported class was really pending
  p_win_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((($past(req) >> cls) & class_map_t'(1)) != '0));
  // R8: class 0 is never reported
  p_no_class0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cls != '0));
  // R9: idle output means nothing was eligible
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($past(elig) == '0 && cls == '0));
  // R7: a closed gate never reports
  p_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(thr) == '1) |-> !valid);
endmodule

// File: rtl/prio_gate.sv
module prio_gate
  import prio_gate_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  output logic             cfg_err,
  input  logic [CLASS_N-1:0] req_pend,
  output logic             win_valid,
  output logic [CLASS_W-1:0] win_class
);
  class_t thr_q;

  prio_gate_thr_reg #(.REG_W(REG_W)) u_thr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .thr     (thr_q),
    .err     (cfg_err)
  );

  assign cfg_rd_data = {{(REG_W-CLASS_W){1'b0}}, thr_q};

  prio_gate_pick u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_pend),
    .thr   (thr_q),
    .valid (win_valid),
    .cls   (win_class)
  );

  // R10: a write shows on the read port right after its edge
  p_rd_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (cfg_rd_data[CLASS_W-1:0] == $past(cfg_wr_data[CLASS_W-1:0])));
endmodule

// File: tb/prio_gate_tb.sv
module prio_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [63:0] cfg_wr_data = '0;
  logic [63:0] cfg_rd_data;
  logic        cfg_err;
  logic [15:0] req_pend = '0;
  logic        win_valid;
  logic [3:0]  win_class;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prio_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cfg_err(cfg_err), .req_pend(req_pend),
    .win_valid(win_valid), .win_class(win_class)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent reference: scan from the top down for a class above the threshold.
  function automatic int ref_pick(input logic [15:0] r, input int t);
    int best = 0;
    foreach (r[i]) if (i >= 1 && r[i] && i > t && i > best) best = i;
    return best;
  endfunction

  task automatic wr(input logic [63:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    step();
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic apply(input string tag, input logic [15:0] r, input int t);
    int e;
    req_pend = r;
    step();
    e = ref_pick(r, t);
    chk({tag, " valid"}, 64'(win_valid), 64'(e != 0));
    chk({tag, " class"}, 64'(win_class), 64'(e));
  endtask

  task automatic t_reset();
    chk("R1 thr", cfg_rd_data, 64'h0);
    chk("R1 valid", 64'(win_valid), 64'h0);
    chk("R1 class", 64'(win_class), 64'h0);
    chk("R1 err", 64'(cfg_err), 64'h0);
  endtask

  task automatic t_readback();
    wr(64'h0000_0000_0000_0007);
    chk("R2 readback", cfg_rd_data, 64'h7);
    chk("R4 no err on clean write", 64'(cfg_err), 64'h0);
  endtask

  task automatic t_reserved();
    wr(64'hA5A5_0000_0F00_00F9);
    chk("R3 reserved ignored", cfg_rd_data, 64'h9);
    chk("R4 err strobe", 64'(cfg_err), 64'h1);
    step();
    chk("R4 err one cycle", 64'(cfg_err), 64'h0);
    chk("R2 upper zero", cfg_rd_data >> 4, 64'h0);
  endtask

  task automatic t_boundary();
    wr(64'h9);
    apply("R5 at threshold", 16'h0200, 9);
    apply("R5 just above", 16'h0600, 9);
    apply("R5 mixed", 16'h1A5E, 9);
  endtask

  task automatic t_open();
    wr(64'h0);
    apply("R6 class1", 16'h0002, 0);
    apply("R6 all", 16'hFFFE, 0);
    apply("R9 sparse", 16'h0890, 0);
  endtask

  task automatic t_closed();
    wr(64'hF);
    apply("R7 all pending", 16'hFFFF, 15);
    apply("R7 top only", 16'h8000, 15);
  endtask

  task automatic t_class0();
    wr(64'h0);
    apply("R8 bit0 alone", 16'h0001, 0);
    apply("R8 bit0 plus 3", 16'h0009, 0);
  endtask

  task automatic t_sweep();
    logic [15:0] pats [4] = '{16'h4242, 16'h00F0, 16'h7FFE, 16'h1004};
    for (int t = 2; t < 15; t += 5) begin
      wr(64'(t));
      for (int k = 0; k < 4; k++) apply("R9 sweep", pats[k], t);
    end
  endtask

  task automatic t_update();
    wr(64'h0);
    req_pend = 16'h0020;
    step();
    // write 5 now: the edge that loads it still filters with the old value
    cfg_wr_en = 1'b1; cfg_wr_data = 64'h5;
    step();
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
    chk("R10 old thr valid", 64'(win_valid), 64'h1);
    chk("R10 old thr class", 64'(win_class), 64'h5);
    step();
    chk("R10 new thr blocks", 64'(win_valid), 64'h0);
    req_pend = '0;
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #9;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_readback();
    t_reserved();
    t_boundary();
    t_open();
    t_closed();
    t_class0();
    t_sweep();
    t_update();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule